// File: doc/BRIEF.md
# Bus-Sizing Transfer Sequencer

This block sits between a DMA channel and a shared system bus. The channel hands it one logical transfer: a byte, half-word or word write, a half-word or word read, or a multi-word burst read. It also gives the width of the memory port the address targets (8, 16 or 32 bits). The sequencer asks for bus ownership and waits for the grant. It then issues the transfer as a run of consecutive physical cycles, each no wider than the port, and keeps ownership until the last cycle is acknowledged. Ownership is released in the following clock, together with a one-clock completion pulse.

Byte order on the bus is big-endian. Bit 3 of the lane-enable vector covers data bits [31:24]. A narrow port sits on the upper lanes. Write data is taken right-aligned from the request, and its most significant byte goes to the lowest address. Read beats are shifted into an accumulator, the first beat ending up in the most significant position. Each finished word is presented with a one-clock valid strobe. A burst delivers its words in address order.

The controller has four named states. In `ST_IDLE` it accepts a request (transition *accept*). In `ST_OWN_WAIT` it holds the ownership request until the grant arrives (transition *granted*). In `ST_BEAT` it runs the bus cycles: it stays there on *next beat* and leaves on *last beat*. `ST_FINISH` drops ownership, pulses completion and returns to idle (transition *release*). An unknown transfer code in `ST_IDLE` leaves the block idle (transition *reject*).

Top module: `bsz_sequencer`

## Requirements
- R1: Transfer codes are 0 = byte write, 1 = half-word write, 2 = word write, 3 = half-word read, 4 = word read, 5 = burst read of BURST_WORDS words. Codes 6 and 7 are rejected: the block stays idle and requests no ownership.
- R2: Port codes are 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. A transfer of S bytes on a port of P bytes takes S / min(P, min(S,4)) bus cycles. A default burst therefore takes 4, 8 or 16 cycles.
- R3: A word read from a 16-bit port takes exactly two cycles. The first cycle supplies bits [31:16] of the result. A half-word read returns its value in rd_data[15:0] with the upper bits zero.
- R4: bus_req rises in the clock after a request is accepted. It stays high without a gap until the final acknowledged cycle and falls in the clock after it.
- R5: Once granted, bus_cyc stays high on every clock until the last cycle is acknowledged. While bus_ack is low, bus_addr and bus_be hold their values.
- R6: After each acknowledged cycle, bus_addr advances by the number of bytes that cycle carried.
- R7: Only the lanes a port wires up are enabled. An 8-bit port uses lane 3 only ([31:24]) and a 16-bit port uses lanes 3 and 2. Within a port, a byte at offset k from the port-aligned address uses lane 3-k.
- R8: A write of S bytes stores exactly S bytes. The byte at address A+k is bits [8(S-1-k)+7 : 8(S-1-k)] of xfer_wdata.
- R9: done is high for exactly one clock, the clock after the final acknowledged cycle. busy is high from acceptance through that clock.
- R10: start is ignored while busy is high. No extra cycles and no second transfer result from it.
- R11: rd_valid pulses once for each completed read word, in the clock after the acknowledge that completes it. A burst yields BURST_WORDS pulses in ascending address order, and writes yield none.
- R12: While rst_n is low and after it is released, bus_req, bus_cyc, done, busy and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| xfer_kind | input | 3 | Transfer code (R1) |
| port_size | input | 2 | Port width code (R2) |
| xfer_addr | input | ADDR_W | Start address, aligned to min(size,4), or 16 for bursts |
| xfer_wdata | input | 32 | Right-aligned write value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| rd_data | output | 32 | Assembled read word |
| rd_valid | output | 1 | rd_data strobe |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Ownership granted |
| bus_cyc | output | 1 | Physical cycle active |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | ADDR_W | Cycle address |
| bus_be | output | 4 | Lane enables, bit 3 = [31:24] |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
A stale beat counter or a wrong beat-size register shows up within the same transfer. The bench sees the wrong number of acknowledged cycles, a lane outside the port, or a byte at the wrong address, and compares these when done arrives. A stuck or misrouted state shows up at once: bus_req drops in the middle of a transfer, bus_cyc leaves a hole, done lasts two clocks, or busy stays high. Packing mistakes surface on the next rd_valid strobe as a word whose bytes are out of order against a memory pattern that does not depend on port width.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    localparam int DW        = 32;
    localparam int BUS_BYTES = DW / 8;
    localparam int LG_W      = 3;

    typedef enum logic [2:0] {
        K_WR8   = 3'd0,
        K_WR16  = 3'd1,
        K_WR32  = 3'd2,
        K_RD16  = 3'd3,
        K_RD32  = 3'd4,
        K_BURST = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OWN_WAIT,
        ST_BEAT,
        ST_FINISH
    } state_e;
endpackage

// File: rtl/bsz_planner.sv
module bsz_planner
    import bsz_pkg::*;
#(
    parameter int BURST_WORDS = 4,
    parameter int CNT_W       = 5
) (
    input  logic [2:0]       kind,
    input  logic [1:0]       port,
    output logic             kind_ok,
    output logic             is_read,
    output logic [1:0]       port_lg,
    output logic [1:0]       beat_lg,
    output logic [1:0]       bpw_lg,
    output logic [CNT_W-1:0] nbeats
);
    localparam logic [LG_W-1:0] BURST_LG = LG_W'(2 + $clog2(BURST_WORDS));

    logic [LG_W-1:0] size_lg;
    logic [1:0]      word_lg;

    always_comb begin
        kind_ok = 1'b1;
        is_read = 1'b0;
        size_lg = '0;
        case (kind)
            K_WR8:   size_lg = LG_W'(0);
            K_WR16:  size_lg = LG_W'(1);
            K_WR32:  size_lg = LG_W'(2);
            K_RD16:  begin is_read = 1'b1; size_lg = LG_W'(1); end
            K_RD32:  begin is_read = 1'b1; size_lg = LG_W'(2); end
            K_BURST: begin is_read = 1'b1; size_lg = BURST_LG; end
            default: kind_ok = 1'b0;
        endcase
        port_lg = (port == 2'd0) ? 2'd0 : (port == 2'd1) ? 2'd1 : 2'd2;
        word_lg = (size_lg > LG_W'(2)) ? 2'd2 : size_lg[1:0];
        beat_lg = (port_lg < word_lg) ? port_lg : word_lg;
        bpw_lg  = word_lg - beat_lg;
        nbeats  = CNT_W'(1) << (size_lg - LG_W'(beat_lg));
    end
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
    import bsz_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [1:0]           addr_lo,
    input  logic [1:0]           port_lg,
    input  logic [1:0]           beat_lg,
    input  logic [CNT_W-1:0]     beat_idx,
    input  logic [CNT_W-1:0]     nbeats,
    input  logic [DW-1:0]        wdata,
    input  logic [DW-1:0]        rdata,
    output logic [BUS_BYTES-1:0] be,
    output logic [DW-1:0]        wlane,
    output logic [DW-1:0]        rchunk
);
    int          bb, offs, pos, wsh;
    logic [DW-1:0] bmask, wchunk;

    always_comb begin
        bb     = 1 << beat_lg;
        offs   = int'(addr_lo) & ((1 << port_lg) - 1);
        // byte distance from the LSB lane to the lowest enabled lane
        pos    = BUS_BYTES - offs - bb;
        bmask  = (bb >= BUS_BYTES) ? '1 : ((DW'(1) << (8 * bb)) - DW'(1));
        be     = BUS_BYTES'(((1 << bb) - 1) << pos);
        // most significant part of the value leaves first
        wsh    = (int'(nbeats) - 1 - int'(beat_idx)) * bb;
        wchunk = (wdata >> (8 * wsh)) & bmask;
        wlane  = wchunk << (8 * pos);
        rchunk = (rdata >> (8 * pos)) & bmask;
    end
endmodule

// File: rtl/bsz_packer.sv
module bsz_packer
    import bsz_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          fire,
    input  logic          word_end,
    input  logic [1:0]    beat_lg,
    input  logic [DW-1:0] chunk,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] acc, merged;

    always_comb merged = (acc << (8 << beat_lg)) | chunk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= fire && word_end;
            if (clear) begin
                acc <= '0;
            end else if (fire) begin
                if (word_end) begin
                    rd_data <= merged;
                    acc     <= '0;
                end else begin
                    acc <= merged;
                end
            end
        end
    end
endmodule

// File: rtl/bsz_sequencer.sv
module bsz_sequencer
    import bsz_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        xfer_kind,
    input  logic [1:0]        port_size,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [31:0]       xfer_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    localparam int MAX_BEATS = BURST_WORDS * BUS_BYTES;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);

    state_e st, st_nx;

    logic             p_ok, p_read;
    logic [1:0]       p_port_lg, p_beat_lg, p_bpw_lg;
    logic [CNT_W-1:0] p_nbeats;

    logic              r_read;
    logic [1:0]        r_port_lg, r_beat_lg, r_bpw_lg;
    logic [CNT_W-1:0]  r_nbeats, r_idx;
    logic [ADDR_W-1:0] r_addr;
    logic [DW-1:0]     r_wdata;

    logic             accept, beat_done, last_beat, word_end;
    logic [CNT_W-1:0] idx_nx, word_mask;
    logic [3:0]       lane_be;
    logic [DW-1:0]    lane_wd, lane_rd;

    bsz_planner #(.BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)) planner_i (
        .kind    (xfer_kind),
        .port    (port_size),
        .kind_ok (p_ok),
        .is_read (p_read),
        .port_lg (p_port_lg),
        .beat_lg (p_beat_lg),
        .bpw_lg  (p_bpw_lg),
        .nbeats  (p_nbeats)
    );

    assign accept    = (st == ST_IDLE) && start && p_ok;
    assign beat_done = (st == ST_BEAT) && bus_ack;
    assign last_beat = (r_idx == r_nbeats - CNT_W'(1));
    assign idx_nx    = r_idx + CNT_W'(1);
    assign word_mask = (CNT_W'(1) << r_bpw_lg) - CNT_W'(1);
    assign word_end  = ((idx_nx & word_mask) == '0);

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (accept) st_nx = ST_OWN_WAIT;
            ST_OWN_WAIT: if (bus_grant) st_nx = ST_BEAT;
            ST_BEAT:     if (bus_ack && last_beat) st_nx = ST_FINISH;
            ST_FINISH:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transfer context and beat progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_read    <= 1'b0;
            r_port_lg <= '0;
            r_beat_lg <= '0;
            r_bpw_lg  <= '0;
            r_nbeats  <= '0;
            r_idx     <= '0;
            r_addr    <= '0;
            r_wdata   <= '0;
        end else if (accept) begin
            r_read    <= p_read;
            r_port_lg <= p_port_lg;
            r_beat_lg <= p_beat_lg;
            r_bpw_lg  <= p_bpw_lg;
            r_nbeats  <= p_nbeats;
            r_idx     <= '0;
            r_addr    <= xfer_addr;
            r_wdata   <= xfer_wdata;
        end else if (beat_done) begin
            r_idx  <= idx_nx;
            r_addr <= r_addr + (ADDR_W'(1) << r_beat_lg);
        end
    end

    bsz_lanes #(.CNT_W(CNT_W)) lanes_i (
        .addr_lo  (r_addr[1:0]),
        .port_lg  (r_port_lg),
        .beat_lg  (r_beat_lg),
        .beat_idx (r_idx),
        .nbeats   (r_nbeats),
        .wdata    (r_wdata),
        .rdata    (bus_rdata),
        .be       (lane_be),
        .wlane    (lane_wd),
        .rchunk   (lane_rd)
    );

    bsz_packer packer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .fire     (beat_done && r_read),
        .word_end (word_end),
        .beat_lg  (r_beat_lg),
        .chunk    (lane_rd),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // state-decoded outputs
    always_comb begin
        bus_req = 1'b0;
        bus_cyc = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (st)
            ST_IDLE:     busy = 1'b0;
            ST_OWN_WAIT: bus_req = 1'b1;
            ST_BEAT:     begin bus_req = 1'b1; bus_cyc = 1'b1; end
            ST_FINISH:   done = 1'b1;
        endcase
        bus_we    = bus_cyc && !r_read;
        bus_addr  = r_addr;
        bus_be    = bus_cyc ? lane_be : 4'd0;
        bus_wdata = bus_we ? lane_wd : '0;
    end
endmodule

// File: rtl/bsz_seq_chk.sv
module bsz_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              rd_valid,
    input logic              bus_req,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be
);
    AST_CYC_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_req); // R4

    AST_REQ_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> done); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_cyc && bus_ack)); // R9

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_cyc && !bus_ack) |-> (bus_cyc && $stable(bus_addr) && $stable(bus_be))); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_cyc && bus_ack) && bus_cyc) |->
            (bus_addr == $past(bus_addr) + ADDR_W'($countones($past(bus_be))))); // R6

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4)); // R7

    AST_RDV_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_cyc && bus_ack && !bus_we)); // R11
endmodule

bind bsz_sequencer bsz_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .rd_valid (rd_valid),
    .bus_req  (bus_req),
    .bus_cyc  (bus_cyc),
    .bus_we   (bus_we),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .bus_be   (bus_be)
);

// File: tb/bsz_sequencer_tb_top.sv
module bsz_sequencer_tb_top;
    localparam int AW = 32;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] xfer_kind = '0;
    logic [1:0] port_size = '0;
    logic [AW-1:0] xfer_addr = '0;
    logic [31:0] xfer_wdata = '0;
    logic busy, done, rd_valid, bus_req, bus_cyc, bus_we;
    logic [31:0] rd_data, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic [3:0] bus_be;
    logic bus_grant = 1'b0;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    bsz_sequencer #(.ADDR_W(AW), .BURST_WORDS(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_kind(xfer_kind),
        .port_size(port_size), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // ---------------- reference functions ----------------
    function automatic int size_of(int k);
        case (k)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 2;
            4: return 4;
            default: return BW * 4;
        endcase
    endfunction

    function automatic int pbytes_of(int p);
        return (p == 0) ? 1 : (p == 1) ? 2 : 4;
    endfunction

    function automatic int beats_of(int k, int p);
        int s, w, b;
        s = size_of(k);
        w = (s > 4) ? 4 : s;
        b = (pbytes_of(p) < w) ? pbytes_of(p) : w;
        return s / b;
    endfunction

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a & 255) * 37 + 11);
    endfunction

    // ---------------- monitor and bus responder ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic clr = 1'b0;
    int cur_pb = 4;
    int cur_exp = 1;
    int beats, done_n, done_cyc, last_ack_cyc, req_gap, cyc_gap, rd_n, lane_err, dup_err, wr_n;
    bit req_seen, cyc_seen;
    logic [31:0] rd_q [16];
    logic [7:0] wr_mem [256];
    bit wr_flag [256];

    always @(negedge clk) begin
        bit ack;
        int base;
        logic [31:0] rd;
        if (clr) begin
            beats = 0; done_n = 0; done_cyc = 0; last_ack_cyc = 0; req_gap = 0;
            cyc_gap = 0; rd_n = 0; lane_err = 0; dup_err = 0; wr_n = 0;
            req_seen = 0; cyc_seen = 0;
            for (int i = 0; i < 256; i++) wr_flag[i] = 0;
        end else begin
            if (bus_req) req_seen = 1;
            if (req_seen && done_n == 0 && !bus_req && !done) req_gap++;
            if (bus_cyc) cyc_seen = 1;
            if (cyc_seen && !bus_cyc && beats < cur_exp) cyc_gap++;
            if (done) begin done_n++; done_cyc = cyc; end
            if (rd_valid && rd_n < 16) begin rd_q[rd_n] = rd_data; rd_n++; end
        end
        if (!bus_req) bus_grant = 1'b0;
        else if (!bus_grant) bus_grant = ($urandom_range(0, 1) == 1);
        ack = 0;
        rd = $urandom;
        if (bus_cyc) begin
            ack = ($urandom_range(0, 3) != 0);
            base = int'(bus_addr[7:0]) & ~(cur_pb - 1);
            for (int k = 0; k < cur_pb; k++) rd[31 - 8 * k -: 8] = mem_byte(base + k);
            if (ack && !clr) begin
                beats++;
                last_ack_cyc = cyc;
                if (bus_we) begin
                    for (int l = 0; l < 4; l++) begin
                        if (bus_be[l]) begin
                            if ((3 - l) >= cur_pb) lane_err++;
                            else begin
                                if (wr_flag[(base + 3 - l) & 255]) dup_err++;
                                wr_flag[(base + 3 - l) & 255] = 1;
                                wr_mem[(base + 3 - l) & 255] = bus_wdata[8 * l +: 8];
                                wr_n++;
                            end
                        end
                    end
                end
            end
        end
        bus_ack = ack;
        bus_rdata = rd;
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_err = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(int k, int p, int a, logic [31:0] wd, bit inject);
        int s, nb, to, bad, nwords;
        logic [31:0] ew;
        s  = size_of(k);
        nb = beats_of(k, p);
        cur_pb = pbytes_of(p);
        cur_exp = nb;
        @(posedge clk); clr = 1'b1;
        @(posedge clk); clr = 1'b0;
        @(negedge clk);
        start = 1'b1; xfer_kind = 3'(k); port_size = 2'(p);
        xfer_addr = AW'(a); xfer_wdata = wd;
        @(negedge clk); start = 1'b0;
        if (inject) begin
            while (!bus_req) @(negedge clk);
            start = 1'b1; xfer_kind = 3'd0; xfer_addr = AW'((a + 64) & 255);
            @(negedge clk); start = 1'b0;
        end
        to = 0;
        while (done_n == 0 && to < 2000) begin @(negedge clk); to++; end
        repeat (3) @(negedge clk);
        chk(to < 2000, "R9", "completion seen", to, 0);
        chk(beats == nb, "R2", "acknowledged cycles", beats, nb);
        chk(done_n == 1 && done_cyc == last_ack_cyc + 1, "R9", "done timing",
            done_cyc - last_ack_cyc, 1);
        chk(req_gap == 0 && req_seen, "R4", "ownership gaps", req_gap, 0);
        chk(cyc_gap == 0, "R5", "cycle gaps", cyc_gap, 0);
        chk(lane_err == 0, "R7", "lanes outside port", lane_err, 0);
        chk(!busy && !bus_req, "R10", "idle after transfer", {busy, bus_req}, 0);
        if (k <= 2) begin
            bad = 0;
            for (int i = 0; i < s; i++)
                if (!wr_flag[(a + i) & 255] || wr_mem[(a + i) & 255] != wd[8 * (s - 1 - i) +: 8]) bad++;
            chk(wr_n == s && dup_err == 0, "R8", "bytes written", wr_n, s);
            chk(bad == 0, "R8", "misplaced write bytes", bad, 0);
            chk(rd_n == 0, "R11", "read strobes on write", rd_n, 0);
        end else begin
            nwords = (k == 5) ? BW : 1;
            chk(rd_n == nwords, "R11", "read words", rd_n, nwords);
            for (int w = 0; w < nwords && w < rd_n; w++) begin
                if (k == 3) ew = {16'h0, mem_byte(a), mem_byte(a + 1)};
                else ew = {mem_byte(a + 4 * w), mem_byte(a + 4 * w + 1),
                           mem_byte(a + 4 * w + 2), mem_byte(a + 4 * w + 3)};
                chk(rd_q[w] == ew, "R3 R6", "read word", rd_q[w], ew);
            end
            chk(wr_n == 0, "R8", "bytes written by read", wr_n, 0);
        end
    endtask

    task automatic run_all();
        int k, p, al, a, bad;
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_cyc && !done && !busy && !rd_valid, "R12", "outputs in reset",
            {bus_req, bus_cyc, done, busy, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!bus_req && !bus_cyc && !done && !busy && !rd_valid, "R12", "outputs after reset",
            {bus_req, bus_cyc, done, busy, rd_valid}, 0);
        // R3: word read from 16-bit port = two cycles
        run_xfer(4, 1, 8'h20, 32'h0, 0);
        // R2: burst on narrow and wide ports
        run_xfer(5, 0, 8'h40, 32'h0, 0);
        run_xfer(5, 2, 8'hF0, 32'h0, 0);
        // R8 R7: writes on each port width at unaligned-in-port offsets
        run_xfer(2, 0, 8'h10, 32'hA1B2C3D4, 0);
        run_xfer(1, 2, 8'h12, 32'h0000BEEF, 0);
        run_xfer(0, 2, 8'h13, 32'h0000005A, 0);
        run_xfer(3, 3, 8'h36, 32'h0, 0);
        // R10: start pulse while busy
        run_xfer(2, 1, 8'h80, 32'h01020304, 1);
        // R1: reserved codes 6 and 7
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            start = 1'b1; xfer_kind = 3'(c); port_size = 2'd2; xfer_addr = '0;
            @(negedge clk); start = 1'b0;
            bad = 0;
            repeat (6) begin @(negedge clk); if (bus_req || busy || done) bad++; end
            chk(bad == 0, "R1", "reserved code accepted", bad, 0);
        end
        // random mix
        for (int t = 0; t < 200; t++) begin
            k  = $urandom_range(0, 5);
            p  = $urandom_range(0, 3);
            al = (size_of(k) > 4) ? 16 : size_of(k);
            a  = $urandom_range(0, 255) & ~(al - 1);
            run_xfer(k, p, a, $urandom, ($urandom_range(0, 7) == 0));
        end
    endtask

    initial begin
        bit wd_fired;
        void'($urandom(32'd4242));
        wd_fired = 0;
        fork
            begin run_all(); end
            begin repeat (150000) @(posedge clk); wd_fired = 1; end
        join_any
        disable fork;
        if (wd_fired) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual %0d expected %0d cycles", 150000, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule